// File: doc/BRIEF.md
# SPI Slave Byte Shift Engine

This block is the serial half of an SPI target device. An external controller drives a serial clock, an active-low select line and a data-in line (MOSI), and the block answers on MISO. All three inputs are brought into the system clock domain through two-flop synchronizers. Their edges are then detected in that domain, so the whole block runs on one clock. The system clock must run at least four times as fast as the serial clock.

Three static configuration inputs set the bus behaviour. The clock polarity sets which level the serial clock idles at. The clock phase decides whether a bit is sampled on the leading edge or on the trailing edge. The order input picks whether the byte travels most-significant or least-significant bit first. On the parallel side, a byte written with a load strobe is held and shifted out in the next byte. The received byte appears together with a one-cycle done pulse, and a busy flag marks a byte in progress. MISO comes with an output-enable, so the pad can be released whenever the device is not selected.

In phase 0 the first outgoing bit is placed on MISO as soon as select falls, before any clock edge. In that phase, select must be released between bytes. In phase 1, bytes may follow one another while select stays low.

Top module: `spi_slave_engine`

## Requirements
- R1: After reset, `miso_oe`, `busy` and `rx_done` are 0 and `rx_byte` is 0x00.
- R2: With `cfg_cpha`=0, the first outgoing bit is on `miso_out` after `ssel_n_in` falls and before the first serial clock edge.
- R3: With `cfg_cpha`=0, MOSI is sampled on the leading clock edge of each bit. The trailing edge shifts the register and presents the next bit. With `cfg_lsb_first`=0, bit 7 travels first, and after eight bits `rx_byte` equals the byte sent on MOSI.
- R4: With `cfg_lsb_first`=1, bit 0 travels first in both directions.
- R5: With `cfg_cpol`=1, the clock idles high. The falling edge is then the leading edge and the rising edge is the trailing edge.
- R6: With `cfg_cpha`=1, `miso_out` is updated on the leading edge of each bit and MOSI is sampled on the trailing edge.
- R7: With `cfg_cpha`=1, consecutive bytes transfer while `ssel_n_in` stays low, and each byte gives its own done pulse.
- R8: With `cfg_cpha`=0, clock edges after the eighth bit are ignored until select is released. A new byte starts only on a fresh falling edge of select.
- R9: If select rises before eight bits have completed, the partial byte is dropped. `rx_done` does not pulse, `rx_byte` keeps its old value and `busy` goes low.
- R10: `miso_oe` is 0 whenever select is high and 1 while the device is selected.
- R11: `rx_done` is a single-cycle pulse, issued exactly once per complete byte at the end of the eighth bit. `busy` is high while a byte is in progress.
- R12: A byte written with `tx_load` is held and sent in the next byte. A load during a byte does not alter the byte in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_cpol | input | 1 | Clock idle level (0 low, 1 high) |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 0: MSB first; 1: LSB first |
| sck_in | input | 1 | Serial clock from the controller |
| ssel_n_in | input | 1 | Select, active low |
| mosi_in | input | 1 | Serial data from the controller |
| miso_out | output | 1 | Serial data to the controller |
| miso_oe | output | 1 | Drive enable for the MISO pad |
| tx_byte | input | DATA_W | Byte to be sent |
| tx_load | input | 1 | Strobe that captures `tx_byte` |
| rx_byte | output | DATA_W | Last complete received byte |
| rx_done | output | 1 | One-cycle pulse when `rx_byte` is updated |
| busy | output | 1 | A byte is in progress |

## Verification
A change on a serial pin takes effect on the third rising system clock edge after it is applied. It passes through two synchronizer flops and an edge-history flop first. So `miso_out`, `miso_oe`, `rx_byte` and `rx_done` all follow their serial cause by three cycles. The bench drives every pin right after a falling clock edge and holds each serial clock phase for five system clocks. It reads outputs only at the end of such a phase, at least two cycles after they have settled and before the next serial edge. Done pulses are counted by a monitor on every clock, so a missing, extra or stretched pulse is caught whenever it lands.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_SHIFT = 2'd1,
    XF_HOLD  = 2'd2
  } xfer_state_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_sync
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
    end else begin
      pipe_q[0] <= pin_in;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign pin_sync = pipe_q[STAGES-1];

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_slave_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              sck_lvl,
  input  logic              ss_lvl,
  input  logic              mosi_lvl,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_load,
  output logic              miso_q,
  output logic              miso_oe,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_done,
  output logic              busy
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  xfer_state_t       state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] tx_hold;
  logic              samp_q;
  logic              sck_prv;
  logic              ss_prv;

  logic sck_rise, sck_fall, ss_rise, ss_fall;
  logic lead_edge, trail_edge;
  logic in_bit;
  logic [DATA_W-1:0] tx_src;
  logic [DATA_W-1:0] shreg_nxt;

  function automatic logic head_bit(input logic [DATA_W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[DATA_W-1];
  endfunction

  function automatic logic [DATA_W-1:0] push_bit(input logic [DATA_W-1:0] v,
                                                 input logic lsb, input logic b);
    return lsb ? {b, v[DATA_W-1:1]} : {v[DATA_W-2:0], b};
  endfunction

  always_comb begin
    sck_rise   = sck_lvl & ~sck_prv;
    sck_fall   = ~sck_lvl & sck_prv;
    ss_rise    = ss_lvl & ~ss_prv;
    ss_fall    = ~ss_lvl & ss_prv;
    lead_edge  = cpol ? sck_fall : sck_rise;
    trail_edge = cpol ? sck_rise : sck_fall;
    in_bit     = cpha ? mosi_lvl : samp_q;
    tx_src     = tx_load ? tx_byte : tx_hold;
    shreg_nxt  = push_bit(shreg, lsb_first, in_bit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= XF_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      tx_hold <= '0;
      samp_q  <= 1'b0;
      sck_prv <= 1'b0;
      ss_prv  <= 1'b1;
      miso_q  <= 1'b0;
      miso_oe <= 1'b0;
      rx_byte <= '0;
      rx_done <= 1'b0;
    end else begin
      sck_prv <= sck_lvl;
      ss_prv  <= ss_lvl;
      rx_done <= 1'b0;
      miso_oe <= ~ss_lvl;
      if (tx_load) tx_hold <= tx_byte;

      if (ss_rise) begin
        state   <= XF_IDLE;
        bit_cnt <= '0;
      end else begin
        unique case (state)
          XF_IDLE: begin
            if (ss_fall) begin
              state   <= XF_SHIFT;
              bit_cnt <= '0;
              shreg   <= tx_src;
              if (!cpha) miso_q <= head_bit(tx_src, lsb_first);
            end
          end
          XF_SHIFT: begin
            if (lead_edge) begin
              if (cpha) miso_q <= head_bit(shreg, lsb_first);
              else      samp_q <= mosi_lvl;
            end
            if (trail_edge) begin
              if (bit_cnt == LAST_BIT) begin
                rx_byte <= shreg_nxt;
                rx_done <= 1'b1;
                bit_cnt <= '0;
                if (cpha) begin
                  shreg <= tx_src;
                end else begin
                  shreg <= shreg_nxt;
                  state <= XF_HOLD;
                end
              end else begin
                shreg   <= shreg_nxt;
                bit_cnt <= bit_cnt + 1'b1;
                if (!cpha) miso_q <= head_bit(shreg_nxt, lsb_first);
              end
            end
          end
          XF_HOLD: begin
            state <= XF_HOLD;
          end
          default: state <= XF_IDLE;
        endcase
      end
    end
  end

  assign busy = (state == XF_SHIFT);

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= LAST_BIT);

  assert_hold_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (state == XF_HOLD && !ss_rise) |=> (state == XF_HOLD));

  assert_abort_clean_R9: assert property (@(posedge clk) disable iff (rst)
    ss_rise |=> (state == XF_IDLE && !rx_done));

  assert_oe_selected_R10: assert property (@(posedge clk) disable iff (rst)
    (state != XF_IDLE) |-> miso_oe);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);

  assert_done_from_shift_R11: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> $past(state == XF_SHIFT));

endmodule

// File: rtl/spi_slave_engine.sv
module spi_slave_engine #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              sck_in,
  input  logic              ssel_n_in,
  input  logic              mosi_in,
  output logic              miso_out,
  output logic              miso_oe,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_load,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_done,
  output logic              busy
);

  localparam int PIN_W = 3;

  logic [PIN_W-1:0] pins_sync;

  spi_pin_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_in  ({mosi_in, ssel_n_in, sck_in}),
    .pin_sync(pins_sync)
  );

  spi_shift_core #(
    .DATA_W(DATA_W)
  ) u_core (
    .clk      (clk),
    .rst      (rst),
    .cpol     (cfg_cpol),
    .cpha     (cfg_cpha),
    .lsb_first(cfg_lsb_first),
    .sck_lvl  (pins_sync[0]),
    .ss_lvl   (pins_sync[1]),
    .mosi_lvl (pins_sync[2]),
    .tx_byte  (tx_byte),
    .tx_load  (tx_load),
    .miso_q   (miso_out),
    .miso_oe  (miso_oe),
    .rx_byte  (rx_byte),
    .rx_done  (rx_done),
    .busy     (busy)
  );

endmodule

// File: tb/spi_slave_engine_bench.sv
module spi_slave_engine_bench;

  localparam int HALF = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
  logic       sck = 1'b0, ssel_n = 1'b1, mosi = 1'b0;
  logic       miso_out, miso_oe;
  logic [7:0] tx_byte = 8'h00;
  logic       tx_load = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_done, busy;

  int n_chk = 0, n_bad = 0, done_cnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spi_slave_engine u_spi_slave_engine (
    .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .sck_in(sck), .ssel_n_in(ssel_n),
    .mosi_in(mosi), .miso_out(miso_out), .miso_oe(miso_oe),
    .tx_byte(tx_byte), .tx_load(tx_load), .rx_byte(rx_byte),
    .rx_done(rx_done), .busy(busy)
  );

  always @(posedge clk) if (!rst && rx_done) done_cnt <= done_cnt + 1;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  function automatic logic bit_at(input logic [7:0] v, input logic lsb, input int i);
    return lsb ? v[i] : v[7-i];
  endfunction

  task automatic load_tx(input logic [7:0] v);
    tx_byte = v; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  task automatic set_cfg(input logic pol, input logic pha, input logic lsb);
    cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb; sck = pol;
    wait_clk(8);
  endtask

  // One byte as a controller; checks MISO bits, received byte and done count.
  task automatic xfer(input logic [7:0] mo, input logic [7:0] exp_mi,
                      input bit start, input bit rel, input bit mid_ld,
                      input logic [7:0] ld_val, input string rq);
    logic [7:0] got = 8'h00;
    int d0 = done_cnt;
    if (start) begin
      if (!cfg_cpha) mosi = bit_at(mo, cfg_lsb_first, 0);
      ssel_n = 1'b0;
      wait_clk(HALF);
      chk(miso_oe == 1'b1, "R10", int'(miso_oe), 1);
      if (!cfg_cpha)
        chk(miso_out == bit_at(exp_mi, cfg_lsb_first, 0), "R2",
            int'(miso_out), int'(bit_at(exp_mi, cfg_lsb_first, 0)));
    end
    for (int i = 0; i < 8; i++) begin
      if (!cfg_cpha) begin
        got[cfg_lsb_first ? i : 7-i] = miso_out;
        sck = ~sck;
        wait_clk(HALF);
        sck = ~sck;
        if (i < 7) mosi = bit_at(mo, cfg_lsb_first, i+1);
      end else begin
        sck = ~sck;
        mosi = bit_at(mo, cfg_lsb_first, i);
        wait_clk(HALF);
        got[cfg_lsb_first ? i : 7-i] = miso_out;
        sck = ~sck;
      end
      if (mid_ld && i == 4) begin
        load_tx(ld_val);
        wait_clk(HALF-1);
      end else begin
        wait_clk(HALF);
      end
      if (i == 3) chk(busy == 1'b1, "R11 busy", int'(busy), 1);
    end
    chk(got == exp_mi, {rq, " miso"}, int'(got), int'(exp_mi));
    chk(rx_byte == mo, {rq, " rx"}, int'(rx_byte), int'(mo));
    chk(done_cnt == d0 + 1, "R11 done", done_cnt - d0, 1);
    if (rel) begin
      ssel_n = 1'b1;
      wait_clk(HALF);
      chk(miso_oe == 1'b0, "R10", int'(miso_oe), 0);
      chk(busy == 1'b0, "R11 idle", int'(busy), 0);
    end
  endtask

  task automatic t_reset;
    chk(miso_oe == 1'b0, "R1 oe", int'(miso_oe), 0);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(rx_done == 1'b0, "R1 done", int'(rx_done), 0);
    chk(rx_byte == 8'h00, "R1 rx", int'(rx_byte), 0);
  endtask

  task automatic t_phase0_msb;
    set_cfg(1'b0, 1'b0, 1'b0);
    load_tx(8'hA5);
    wait_clk(4);
    xfer(8'h3C, 8'hA5, 1'b1, 1'b1, 1'b0, 8'h00, "R3 R12");
  endtask

  task automatic t_phase0_lsb;
    set_cfg(1'b0, 1'b0, 1'b1);
    load_tx(8'h96);
    xfer(8'hC1, 8'h96, 1'b1, 1'b1, 1'b0, 8'h00, "R4");
  endtask

  task automatic t_pol1;
    set_cfg(1'b1, 1'b0, 1'b0);
    load_tx(8'h5A);
    xfer(8'hE7, 8'h5A, 1'b1, 1'b1, 1'b0, 8'h00, "R5");
  endtask

  task automatic t_phase1;
    set_cfg(1'b0, 1'b1, 1'b0);
    load_tx(8'h81);
    xfer(8'h42, 8'h81, 1'b1, 1'b1, 1'b0, 8'h00, "R6");
  endtask

  task automatic t_back_to_back;
    set_cfg(1'b1, 1'b1, 1'b1);
    load_tx(8'h17);
    xfer(8'h99, 8'h17, 1'b1, 1'b0, 1'b1, 8'h6E, "R7 R12");
    xfer(8'h24, 8'h6E, 1'b0, 1'b1, 1'b0, 8'h00, "R7");
  endtask

  task automatic t_abort;
    int d0;
    logic [7:0] prev;
    set_cfg(1'b0, 1'b0, 1'b0);
    load_tx(8'hFF);
    d0 = done_cnt; prev = rx_byte;
    ssel_n = 1'b0; wait_clk(HALF);
    for (int i = 0; i < 4; i++) begin
      sck = ~sck; mosi = ~mosi; wait_clk(HALF);
      sck = ~sck; wait_clk(HALF);
    end
    ssel_n = 1'b1;
    wait_clk(2*HALF);
    chk(done_cnt == d0, "R9 done", done_cnt - d0, 0);
    chk(rx_byte == prev, "R9 rx", int'(rx_byte), int'(prev));
    chk(busy == 1'b0, "R9 busy", int'(busy), 0);
    load_tx(8'hC3);
    xfer(8'h5E, 8'hC3, 1'b1, 1'b1, 1'b0, 8'h00, "R9 after");
  endtask

  task automatic t_hold;
    int d0;
    set_cfg(1'b0, 1'b0, 1'b0);
    load_tx(8'h0F);
    xfer(8'hB2, 8'h0F, 1'b1, 1'b0, 1'b0, 8'h00, "R8");
    d0 = done_cnt;
    for (int i = 0; i < 8; i++) begin
      sck = ~sck; mosi = ~mosi; wait_clk(HALF);
      sck = ~sck; wait_clk(HALF);
    end
    chk(done_cnt == d0, "R8 extra", done_cnt - d0, 0);
    chk(busy == 1'b0, "R8 busy", int'(busy), 0);
    chk(rx_byte == 8'hB2, "R8 rx", int'(rx_byte), 8'hB2);
    ssel_n = 1'b1; wait_clk(2*HALF);
    load_tx(8'h6D);
    xfer(8'h4B, 8'h6D, 1'b1, 1'b1, 1'b0, 8'h00, "R8 fresh");
  endtask

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(1);
    t_reset();
    t_phase0_msb();
    t_phase0_lsb();
    t_pol1();
    t_phase1();
    t_back_to_back();
    t_abort();
    t_hold();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule